// File: doc/BRIEF.md
# SPI Master Shift Engine with Status Flags

This block is an 8-bit serial peripheral master. The host places a byte in a one-deep transmit holding register. The engine moves that byte into its shifter and clocks it out most significant bit first on the serial data output. At the same time it gathers the byte arriving on the serial data input into a receive holding register. The serial clock runs at half the core clock: each half of a bit period lasts one core cycle. Bytes written while a transfer is running follow on without a gap in the serial clock.

The host sees four status outputs: transmit register empty, receive register full, transfer complete and overrun. One interrupt output follows a selectable source. The two-bit mode input sets the clock idle level and the sampling edge. Where the complete and overrun flags land relative to receive-full depends on the mode. Dropping the enable input stops any transfer at once and clears the status flags.

Top module: `spim_core`

## Requirements
- R1: `sclk` idles at `mode[1]` (0 low, 1 high) whenever no transfer is running. During a transfer it toggles on every core cycle, so one byte gives exactly 8 full clock pulses.
- R2: `tx_empty` reads 1 one cycle after `en` rises and drops to 0 the cycle after a write is accepted. A `tx_wr` is ignored while `tx_empty` is 0 or `en` is 0.
- R3: When the engine is idle, a held byte moves into the shifter one cycle after the write. On that same cycle `mosi` shows bit 7 and `tx_empty` returns to 1. Bits go out in the order 7 down to 0.
- R4: `mode[0]`=0 samples `miso` on the leading `sclk` edge and drives `mosi` on the trailing edge. `mode[0]`=1 does the reverse. `rx_data` holds the 8 sampled bits, the first sample in bit 7.
- R5: If a byte is waiting when the last edge of a byte occurs, the next byte loads on that edge. Its first edge follows on the next cycle, and its capture comes exactly 16 cycles after the previous capture.
- R6: `rx_full` rises on the cycle of the edge that samples the 8th bit. That is 17 cycles after the write strobe when `mode[0]`=0 and 18 cycles when `mode[0]`=1. It stays high until `rx_rd`.
- R7: `spi_done` rises on the 16th `sclk` edge of a byte. That is one cycle after `rx_full` when `mode[0]`=0 and on the same cycle when `mode[0]`=1. It stays high until `stat_rd`.
- R8: `overrun` sets one cycle before a capture if `rx_full` is still high at that point. It stays set through `rx_rd` until `stat_rd`. The capture then overwrites `rx_data`.
- R9: With `irq_sel`=0, `irq` equals `tx_empty`, but only after the first byte since enabling has been loaded into the shifter. With `irq_sel`=1, `irq` equals `spi_done`.
- R10: One cycle after `en` is 0, `tx_empty`, `rx_full`, `spi_done`, `overrun` and `irq` are all 0 and any transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| mode | input | 2 | {clock idle level, sample on trailing edge} |
| irq_sel | input | 1 | Interrupt source: 0 transmit empty, 1 transfer complete |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| stat_rd | input | 1 | Status read strobe, clears complete and overrun |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| rx_data | output | 8 | Receive holding register |
| tx_empty | output | 1 | Transmit holding register free |
| rx_full | output | 1 | Receive holding register loaded |
| spi_done | output | 1 | Byte transfer complete |
| overrun | output | 1 | Received byte overwrote an unread one |
| irq | output | 1 | Interrupt request |

## Verification
A bad edge counter shows up within one byte. The capture cycle of `rx_full` moves off its exact count, the gap between `rx_full` and `spi_done` is wrong for the mode, or the looped-back byte comes back shifted. A sampling or driving edge swapped in the sequencer corrupts the returned byte on its first transfer. A stale holding-register flag shows up as a second, unrequested byte or a missing one within about 20 cycles. A wrong disable path or a wrong interrupt arming term appears on `tx_empty` or `irq` in the cycle after the stimulus.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Sequencer activity
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;

    // Host-visible flag state
    typedef struct packed {
        logic en;     // registered enable
        logic full;   // transmit holding register occupied
        logic arm;    // first byte has reached the shifter
        logic rxf;    // receive holding register full
        logic ovr;    // overrun, sticky
        logic done;   // transfer complete, sticky
    } flag_t;

endpackage

// File: rtl/spim_seq.sv
module spim_seq #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cpol,
    input  logic cpha,
    input  logic buf_full,
    output logic sclk,
    output logic load,
    output logic drive_stb,
    output logic samp_stb,
    output logic cap_stb,
    output logic pre_cap_stb,
    output logic last_stb
);
    import spim_pkg::*;

    localparam int EDGES = 2 * DATA_W;
    localparam int CNT_W = $clog2(EDGES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    typedef struct packed {
        seq_mode_e        st;
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } seq_t;

    seq_t q, d;
    logic active;
    logic at_last;
    logic [CNT_W-1:0] cap_idx;
    logic [CNT_W-1:0] pre_idx;

    always_comb begin
        active      = en && (q.st == SEQ_RUN);
        at_last     = active && (q.cnt == LAST);
        load        = en && buf_full && ((q.st == SEQ_IDLE) || at_last);
        cap_idx     = cpha ? LAST : (LAST - CNT_W'(1));
        pre_idx     = cap_idx - CNT_W'(1);
        samp_stb    = active && (q.cnt[0] == cpha);
        drive_stb   = active && (cpha ? !q.cnt[0] : (q.cnt[0] && !at_last));
        cap_stb     = samp_stb && (q.cnt == cap_idx);
        pre_cap_stb = active && (q.cnt == pre_idx);
        last_stb    = at_last;

        d = q;
        if (!en) begin
            d.st   = SEQ_IDLE;
            d.cnt  = '0;
            d.sclk = cpol;
        end else if (active) begin
            d.sclk = ~q.sclk;
            if (at_last) begin
                d.cnt = '0;
                d.st  = load ? SEQ_RUN : SEQ_IDLE;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end else begin
            d.sclk = cpol;
            d.cnt  = '0;
            if (load) d.st = SEQ_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SEQ_IDLE, cnt: '0, sclk: 1'b0};
        else        q <= d;
    end

    assign sclk = q.sclk;

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpha,
    input  logic              miso,
    input  logic              wr_accept,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              drive_stb,
    input  logic              samp_stb,
    input  logic              cap_stb,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] txbuf;
        logic [DATA_W-1:0] tsh;
        logic [DATA_W-2:0] rsh;
        logic              mosi;
        logic [DATA_W-1:0] rxbuf;
    } shift_t;

    shift_t q, d;

    always_comb begin
        d = q;
        if (wr_accept) d.txbuf = wr_data;

        if (!en) begin
            d.mosi = 1'b0;
        end else if (load) begin
            d.tsh  = q.txbuf;
            d.mosi = q.txbuf[MSB];
        end else if (drive_stb) begin
            d.mosi = cpha ? q.tsh[MSB] : q.tsh[MSB-1];
            d.tsh  = {q.tsh[MSB-1:0], 1'b0};
        end

        if (samp_stb) d.rsh   = {q.rsh[DATA_W-3:0], miso};
        if (cap_stb)  d.rxbuf = {q.rsh, miso};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mosi    = q.mosi;
    assign rx_data = q.rxbuf;

endmodule

// File: rtl/spim_flags.sv
module spim_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tx_wr,
    input  logic rx_rd,
    input  logic stat_rd,
    input  logic irq_sel,
    input  logic load,
    input  logic cap_stb,
    input  logic pre_cap_stb,
    input  logic last_stb,
    output logic wr_accept,
    output logic buf_full,
    output logic tx_empty,
    output logic rx_full,
    output logic spi_done,
    output logic overrun,
    output logic irq
);
    import spim_pkg::*;

    flag_t q, d;

    always_comb begin
        wr_accept = en && tx_wr && !q.full;

        d    = q;
        d.en = en;
        if (!en) begin
            d.full = 1'b0;
            d.arm  = 1'b0;
            d.rxf  = 1'b0;
            d.ovr  = 1'b0;
            d.done = 1'b0;
        end else begin
            if (wr_accept)  d.full = 1'b1;
            else if (load)  d.full = 1'b0;

            if (load) d.arm = 1'b1;

            if (cap_stb)    d.rxf = 1'b1;
            else if (rx_rd) d.rxf = 1'b0;

            if (pre_cap_stb && q.rxf && !rx_rd) d.ovr = 1'b1;
            else if (stat_rd)                   d.ovr = 1'b0;

            if (last_stb)     d.done = 1'b1;
            else if (stat_rd) d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign buf_full = q.full;
    assign tx_empty = q.en && !q.full;
    assign rx_full  = q.rxf;
    assign spi_done = q.done;
    assign overrun  = q.ovr;
    assign irq      = irq_sel ? q.done : (tx_empty && q.arm);

endmodule

// File: rtl/spim_core.sv
module spim_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic              irq_sel,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              stat_rd,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              spi_done,
    output logic              overrun,
    output logic              irq
);
    logic cpol, cpha;
    logic buf_full, wr_accept, load;
    logic drive_stb, samp_stb, cap_stb, pre_cap_stb, last_stb;

    assign cpol = mode[1];
    assign cpha = mode[0];

    spim_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cpol       (cpol),
        .cpha       (cpha),
        .buf_full   (buf_full),
        .sclk       (sclk),
        .load       (load),
        .drive_stb  (drive_stb),
        .samp_stb   (samp_stb),
        .cap_stb    (cap_stb),
        .pre_cap_stb(pre_cap_stb),
        .last_stb   (last_stb)
    );

    spim_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cpha     (cpha),
        .miso     (miso),
        .wr_accept(wr_accept),
        .wr_data  (tx_data),
        .load     (load),
        .drive_stb(drive_stb),
        .samp_stb (samp_stb),
        .cap_stb  (cap_stb),
        .mosi     (mosi),
        .rx_data  (rx_data)
    );

    spim_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tx_wr      (tx_wr),
        .rx_rd      (rx_rd),
        .stat_rd    (stat_rd),
        .irq_sel    (irq_sel),
        .load       (load),
        .cap_stb    (cap_stb),
        .pre_cap_stb(pre_cap_stb),
        .last_stb   (last_stb),
        .wr_accept  (wr_accept),
        .buf_full   (buf_full),
        .tx_empty   (tx_empty),
        .rx_full    (rx_full),
        .spi_done   (spi_done),
        .overrun    (overrun),
        .irq        (irq)
    );

endmodule

// File: rtl/spim_core_chk.sv
module spim_core_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic tx_wr,
    input logic rx_rd,
    input logic stat_rd,
    input logic sclk,
    input logic tx_empty,
    input logic rx_full,
    input logic spi_done,
    input logic overrun,
    input logic irq
);

    // R1: clock parks at its idle level while disabled
    p_idle_sclk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sclk == $past(cpol)));

    // R2: an accepted write fills the holding register
    p_txe_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tx_wr && tx_empty) |=> !tx_empty);

    // R6: receive-full holds until read
    p_rxfull_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_full && !rx_rd) |=> rx_full);

    // R7: complete holds until status read
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && spi_done && !stat_rd) |=> spi_done);

    // R8: overrun is sticky until status read
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && overrun && !stat_rd) |=> overrun);

    // R10: disable clears every flag and the interrupt
    p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!tx_empty && !rx_full && !spi_done && !overrun && !irq));

endmodule

bind spim_core spim_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cpol    (mode[1]),
    .tx_wr   (tx_wr),
    .rx_rd   (rx_rd),
    .stat_rd (stat_rd),
    .sclk    (sclk),
    .tx_empty(tx_empty),
    .rx_full (rx_full),
    .spi_done(spi_done),
    .overrun (overrun),
    .irq     (irq)
);

// File: tb/spim_core_tb.sv
`timescale 1ns/1ps
module spim_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       irq_sel = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rd_man = 1'b0;
    logic       rd_mon = 1'b0;
    logic       stat_rd = 1'b0;
    logic       inv = 1'b0;
    logic       mon_en = 1'b0;
    logic       rx_rd, miso, sclk, mosi, tx_empty, rx_full, spi_done, overrun, irq;
    logic [7:0] rx_data;

    int checks = 0, failures = 0;
    int mon_checks = 0, mon_fails = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    assign rx_rd = rd_man | rd_mon;
    assign miso  = inv ? ~mosi : mosi;

    spim_core u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .irq_sel(irq_sel),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .stat_rd(stat_rd),
        .miso(miso), .sclk(sclk), .mosi(mosi), .rx_data(rx_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .spi_done(spi_done),
        .overrun(overrun), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        tx_data = b;
        tx_wr   = 1'b1;
        tick();
        tx_wr   = 1'b0;
    endtask

    // Scoreboard driver: push the expected received byte, then write
    task automatic send(input logic [7:0] b);
        exp_q.push_back(inv ? ~b : b);
        write_byte(b);
    endtask

    task automatic pulse_rd;
        rd_man = 1'b1; tick(); rd_man = 1'b0;
    endtask

    task automatic pulse_stat;
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    // Scoreboard monitor: pops on each receive-full and reads the byte out (R4)
    always @(negedge clk) begin
        if (rd_mon) begin
            rd_mon <= 1'b0;
        end else if (mon_en && rx_full) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_fails++;
                $display("FAIL R4 unexpected byte actual=%0h expected=none", rx_data);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (rx_data !== e) begin
                    mon_fails++;
                    $display("FAIL R4 actual=%0h expected=%0h", rx_data, e);
                end
            end
            rd_mon <= 1'b1;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, failures + mon_fails + 1);
        $finish;
    end

    initial begin
        int c;
        int rises;
        logic prev;
        logic [7:0] pat [4];
        pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h81; pat[3] = 8'h6E;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state (R10)
        check(tx_empty == 1'b0 && rx_full == 1'b0 && irq == 1'b0, "R10 reset flags",
              32'({tx_empty, rx_full, irq}), 32'd0);
        check(sclk == 1'b0 && overrun == 1'b0 && spi_done == 1'b0, "R10 reset sclk/ovr/done",
              32'({sclk, overrun, spi_done}), 32'd0);

        // Idle level follows mode[1] (R1)
        mode = 2'd2; tick(); tick();
        check(sclk == 1'b1, "R1 idle high", 32'(sclk), 32'd1);
        mode = 2'd0; tick(); tick();
        check(sclk == 1'b0, "R1 idle low", 32'(sclk), 32'd0);

        // Enable: tx_empty up, no interrupt yet (R2, R9)
        en = 1'b1; tick();
        check(tx_empty == 1'b1, "R2 empty after enable", 32'(tx_empty), 32'd1);
        check(irq == 1'b0, "R9 no irq before first load", 32'(irq), 32'd0);

        // Mode 0 timing
        write_byte(8'hA5); c = 1;
        check(tx_empty == 1'b0, "R2 cleared by write", 32'(tx_empty), 32'd0);
        check(irq == 1'b0, "R9 irq low while buffer full", 32'(irq), 32'd0);
        tick(); c = 2;
        check(tx_empty == 1'b1 && mosi == 1'b1, "R3 load shows bit 7", 32'({tx_empty, mosi}), 32'h3);
        check(irq == 1'b1, "R9 irq armed after load", 32'(irq), 32'd1);
        rises = 0; prev = sclk;
        while (!rx_full && c < 60) begin
            tick(); c++;
            if (sclk && !prev) rises++;
            prev = sclk;
        end
        check(c == 17, "R6 rx_full cycle mode0", 32'(c), 32'd17);
        check(rx_data == 8'hA5, "R4 mode0 data", 32'(rx_data), 32'hA5);
        check(rises == 8, "R1 eight pulses", 32'(rises), 32'd8);
        check(spi_done == 1'b0, "R7 done not yet mode0", 32'(spi_done), 32'd0);
        tick();
        check(spi_done == 1'b1 && sclk == 1'b0, "R7 done half bit later", 32'({spi_done, sclk}), 32'h2);
        pulse_rd();
        check(rx_full == 1'b0, "R6 cleared by read", 32'(rx_full), 32'd0);
        pulse_stat();
        check(spi_done == 1'b0, "R7 cleared by status read", 32'(spi_done), 32'd0);

        // Mode 1 timing: complete with capture (R6, R7)
        mode = 2'd1; tick();
        write_byte(8'h3C); c = 1;
        while (!rx_full && c < 60) begin tick(); c++; end
        check(c == 18, "R6 rx_full cycle mode1", 32'(c), 32'd18);
        check(spi_done == 1'b1, "R7 done same edge mode1", 32'(spi_done), 32'd1);
        check(rx_data == 8'h3C, "R4 mode1 data", 32'(rx_data), 32'h3C);
        pulse_rd(); pulse_stat();

        // Scoreboard over all modes, back-to-back pairs (R4, R5)
        mon_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            inv  = (m == 3);
            tick();
            for (int i = 0; i < 4; i++) begin
                c = 0;
                while (!tx_empty && c < 60) begin tick(); c++; end
                send(pat[i] ^ 8'(m));
            end
            c = 0;
            while ((exp_q.size() != 0 || !tx_empty || sclk != mode[1]) && c < 200) begin tick(); c++; end
            tick(); tick(); tick();
            check(exp_q.size() == 0, "R4 all bytes received", 32'(exp_q.size()), 32'd0);
            check(overrun == 1'b0, "R8 no overrun when read", 32'(overrun), 32'd0);
        end
        mon_en = 1'b0; inv = 1'b0;
        tick(); tick();
        pulse_stat();

        // Overrun and back-to-back spacing, mode 0 (R5, R8)
        mode = 2'd0; tick();
        write_byte(8'h81); c = 1;
        tick(); c = 2;
        write_byte(8'h42); c = 3;
        while (!overrun && c < 80) begin tick(); c++; end
        check(c == 32, "R8 overrun cycle", 32'(c), 32'd32);
        check(rx_data == 8'h81, "R8 old byte before capture", 32'(rx_data), 32'h81);
        tick();
        check(rx_full == 1'b1 && rx_data == 8'h42, "R5 second capture 16 cycles later", 32'(rx_data), 32'h42);
        pulse_rd();
        check(overrun == 1'b1, "R8 sticky through rx read", 32'(overrun), 32'd1);
        pulse_stat();
        check(overrun == 1'b0, "R8 cleared by status read", 32'(overrun), 32'd0);

        // Write ignored while buffer occupied (R2)
        write_byte(8'hC3);
        write_byte(8'h5A);
        c = 0;
        while (!rx_full && c < 60) begin tick(); c++; end
        check(rx_data == 8'hC3, "R2 first byte sent", 32'(rx_data), 32'hC3);
        pulse_rd();
        repeat (40) tick();
        check(rx_full == 1'b0 && tx_empty == 1'b1, "R2 second write ignored", 32'({rx_full, tx_empty}), 32'h1);
        pulse_stat();

        // Complete as interrupt source (R9)
        irq_sel = 1'b1; tick();
        check(irq == 1'b0, "R9 irq low before complete", 32'(irq), 32'd0);
        write_byte(8'h99);
        c = 0;
        while (!spi_done && c < 60) begin tick(); c++; end
        check(irq == 1'b1, "R9 irq follows complete", 32'(irq), 32'd1);
        pulse_rd(); pulse_stat();
        check(irq == 1'b0, "R9 irq cleared by status read", 32'(irq), 32'd0);
        irq_sel = 1'b0;

        // Disable mid-transfer (R10)
        mode = 2'd3; tick(); tick();
        write_byte(8'hF0);
        repeat (6) tick();
        en = 1'b0; tick();
        check(sclk == 1'b1, "R10 sclk idle after disable", 32'(sclk), 32'd1);
        check({tx_empty, rx_full, spi_done, overrun, irq} == 5'd0, "R10 flags cleared",
              32'({tx_empty, rx_full, spi_done, overrun, irq}), 32'd0);
        // Write while disabled is ignored (R2)
        write_byte(8'h11);
        en = 1'b1; tick();
        check(tx_empty == 1'b1 && irq == 1'b0, "R2 disabled write ignored, R9 rearm",
              32'({tx_empty, irq}), 32'h2);
        repeat (40) tick();
        check(rx_full == 1'b0, "R10 no transfer after disable", 32'(rx_full), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fails);
        $finish;
    end
endmodule